// File: doc/BRIEF.md
# Dual Cascadable Accumulator Adder-Subtractor

This block holds two 16-bit adder-subtractor/accumulator halves, an upper (top) half and a lower (bottom) half. Together they form one 32-bit result word. Each half adds or subtracts two operands and can keep a running total in its accumulator register.

The first operand of each half comes from one of four sources: a raw data input, an 8x8 product, one half of the 16x16 product, or a sign extension. The second operand is either the half's own accumulator or a preload word (C for the top half, D for the bottom half). The carry-in of each half is a constant or a cascade carry. The top half can take its carry from the bottom half. The bottom half can take its carry from a neighbouring block.

The multipliers sit outside this block, and their products arrive as inputs. For each half, an output selector picks one of four values: the live sum, the registered sum, the 8x8 product or the 16x16 product half. The block drives a combinational carry-out, a registered accumulate-carry-out and a sign-extension-out, so that a chain of blocks can be built wider.

Top module: `dual_accum_addsub`

## Requirements
- R1: The bottom operand Z is chosen by `bot_z_sel_i`: 0 gives `b_i`, 1 gives `prod8_bot_i`, 2 gives `prod16_i[15:0]`, and 3 gives 16 copies of `casc_sext_i`.
- R2: The top operand X is chosen by `top_x_sel_i`: 0 gives `a_i`, 1 gives `prod8_top_i`, 2 gives `prod16_i[31:16]`, and 3 gives 16 copies of bit 15 of the bottom Z operand. `sext_o` equals bit 15 of X.
- R3: The second operand of a half is its own accumulator register when its select (`top_w_sel_i` / `bot_y_sel_i`) is 0. When the select is 1, it is `c_i` for the top half and `d_i` for the bottom half.
- R4: A carry-in select of 0 gives 0 and 1 gives 1. For the top half, 2 gives the bottom registered carry and 3 gives the bottom live carry-out. For the bottom half, 2 gives `casc_acc_ci_i` and 3 gives `casc_ci_i`.
- R5: When the subtract control is 0, a half computes W + X + cin. When it is 1, the half computes W + ~X + cin, so cin=1 yields W − X. Bit 16 of the 17-bit result is the carry, and `co_o` is the top half's carry.
- R6: On a clock edge with `ce_i`=1, a high clear input (`top_clr_i` / `bot_clr_i`) sets that half's accumulator and registered carry to 0, whatever the load and hold inputs are.
- R7: On a clock edge with `ce_i`=1, clear low and load high, the accumulator takes `c_i` (top) or `d_i` (bottom) and the registered carry becomes 0, even if hold is high.
- R8: With `ce_i`=1 and clear and load low, hold=1 keeps the accumulator and carry. Hold=0 captures the 16-bit sum and its carry. `acc_co_o` is the top half's registered carry.
- R9: When `ce_i`=0, no accumulator or carry register changes.
- R10: Each half's output is chosen by its 2-bit select: 0 gives the live sum, 1 the accumulator, 2 the half's 8x8 product, and 3 its 16x16 product half. `result_o` = {top, bottom}.
- R11: When `rst_ni` is low, all registers clear at once (asynchronously).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for all registers |
| a_i | input | 16 | Top raw operand |
| b_i | input | 16 | Bottom raw operand |
| c_i | input | 16 | Top preload / W operand |
| d_i | input | 16 | Bottom preload / Y operand |
| prod8_top_i | input | 16 | Upper 8x8 product |
| prod8_bot_i | input | 16 | Lower 8x8 product |
| prod16_i | input | 32 | 16x16 product |
| top_x_sel_i | input | 2 | Top X source select |
| bot_z_sel_i | input | 2 | Bottom Z source select |
| top_w_sel_i | input | 1 | Top W: accumulator / C |
| bot_y_sel_i | input | 1 | Bottom Y: accumulator / D |
| top_ci_sel_i | input | 2 | Top carry-in select |
| bot_ci_sel_i | input | 2 | Bottom carry-in select |
| top_out_sel_i | input | 2 | Top output select |
| bot_out_sel_i | input | 2 | Bottom output select |
| top_sub_i | input | 1 | Top subtract |
| bot_sub_i | input | 1 | Bottom subtract |
| top_load_i | input | 1 | Top load from C |
| bot_load_i | input | 1 | Bottom load from D |
| top_hold_i | input | 1 | Top hold |
| bot_hold_i | input | 1 | Bottom hold |
| top_clr_i | input | 1 | Top synchronous clear |
| bot_clr_i | input | 1 | Bottom synchronous clear |
| casc_acc_ci_i | input | 1 | Accumulate carry from previous block |
| casc_ci_i | input | 1 | Carry from previous block |
| casc_sext_i | input | 1 | Sign extension from previous block |
| result_o | output | 32 | {top output, bottom output} |
| co_o | output | 1 | Top live carry-out |
| acc_co_o | output | 1 | Top registered carry-out |
| sext_o | output | 1 | Bit 15 of top X |

## Verification
Directed sweeps step each source, carry and output selector through all four codes, using data whose values differ in every source. A wrong code mapping therefore changes the result word. A bottom sum of 0xFFFF+1 separates the live carry from the registered carry, because the two differ for one cycle. Collisions of load, hold and clear with the clock enable low expose priority mistakes. Seeded random cycles with occasional control pulses then drive add, subtract and accumulate chains against a bench model.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [1:0] {SRC_RAW = 2'd0, SRC_P8 = 2'd1, SRC_P16 = 2'd2, SRC_EXT = 2'd3} src_sel_e;
  typedef enum logic [1:0] {CI_ZERO = 2'd0, CI_ONE = 2'd1, CI_ACC = 2'd2, CI_CO = 2'd3} ci_sel_e;
  typedef enum logic [1:0] {OUT_SUM = 2'd0, OUT_REG = 2'd1, OUT_P8 = 2'd2, OUT_P16 = 2'd3} out_sel_e;
endpackage

// File: rtl/dacc_operand_mux.sv
module dacc_operand_mux
  import dacc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] p8_i,
  input  logic [W-1:0] p16_i,
  input  logic [W-1:0] ext_i,
  input  logic [1:0]   x_sel_i,
  input  logic [W-1:0] pre_i,
  input  logic [W-1:0] acc_i,
  input  logic         w_sel_i,
  input  logic [1:0]   ci_sel_i,
  input  logic         casc_acc_ci_i,
  input  logic         casc_ci_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] w_o,
  output logic         cin_o
);
  always_comb begin
    unique case (src_sel_e'(x_sel_i))
      SRC_RAW: x_o = raw_i;
      SRC_P8:  x_o = p8_i;
      SRC_P16: x_o = p16_i;
      default: x_o = ext_i;
    endcase
  end

  assign w_o = w_sel_i ? pre_i : acc_i;

  always_comb begin
    unique case (ci_sel_e'(ci_sel_i))
      CI_ZERO: cin_o = 1'b0;
      CI_ONE:  cin_o = 1'b1;
      CI_ACC:  cin_o = casc_acc_ci_i;
      default: cin_o = casc_ci_i;
    endcase
  end
endmodule

// File: rtl/dacc_acc_reg.sv
module dacc_acc_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         hold_i,
  input  logic [W-1:0] pre_i,
  input  logic [W-1:0] sum_i,
  input  logic         co_i,
  output logic [W-1:0] acc_o,
  output logic         acc_co_o
);
  // priority: clear > load > hold, all gated by ce
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o    <= '0;
      acc_co_o <= 1'b0;
    end else if (ce_i) begin
      if (clr_i) begin
        acc_o    <= '0;
        acc_co_o <= 1'b0;
      end else if (load_i) begin
        acc_o    <= pre_i;
        acc_co_o <= 1'b0;
      end else if (!hold_i) begin
        acc_o    <= sum_i;
        acc_co_o <= co_i;
      end
    end
  end
endmodule

// File: rtl/dacc_half.sv
module dacc_half
  import dacc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] p8_i,
  input  logic [W-1:0] p16_i,
  input  logic [W-1:0] ext_i,
  input  logic [W-1:0] pre_i,
  input  logic [1:0]   x_sel_i,
  input  logic         w_sel_i,
  input  logic [1:0]   ci_sel_i,
  input  logic [1:0]   out_sel_i,
  input  logic         casc_acc_ci_i,
  input  logic         casc_ci_i,
  input  logic         sub_i,
  input  logic         load_i,
  input  logic         hold_i,
  input  logic         clr_i,
  output logic [W-1:0] x_o,
  output logic         co_o,
  output logic [W-1:0] acc_o,
  output logic         acc_co_o,
  output logic [W-1:0] out_o
);
  logic [W-1:0] w_op, x_eff;
  logic         cin;
  logic [W:0]   sum_full;

  dacc_operand_mux #(.W(W)) u_mux (
    .raw_i(raw_i), .p8_i(p8_i), .p16_i(p16_i), .ext_i(ext_i), .x_sel_i(x_sel_i),
    .pre_i(pre_i), .acc_i(acc_o), .w_sel_i(w_sel_i),
    .ci_sel_i(ci_sel_i), .casc_acc_ci_i(casc_acc_ci_i), .casc_ci_i(casc_ci_i),
    .x_o(x_o), .w_o(w_op), .cin_o(cin)
  );

  assign x_eff    = sub_i ? ~x_o : x_o;
  assign sum_full = {1'b0, w_op} + {1'b0, x_eff} + {{W{1'b0}}, cin};
  assign co_o     = sum_full[W];

  dacc_acc_reg #(.W(W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .clr_i(clr_i), .load_i(load_i),
    .hold_i(hold_i), .pre_i(pre_i), .sum_i(sum_full[W-1:0]), .co_i(sum_full[W]),
    .acc_o(acc_o), .acc_co_o(acc_co_o)
  );

  always_comb begin
    unique case (out_sel_e'(out_sel_i))
      OUT_SUM: out_o = sum_full[W-1:0];
      OUT_REG: out_o = acc_o;
      OUT_P8:  out_o = p8_i;
      default: out_o = p16_i;
    endcase
  end
endmodule

// File: rtl/dual_accum_addsub.sv
module dual_accum_addsub #(
  parameter int W = 16,
  localparam int RW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  input  logic [W-1:0]  d_i,
  input  logic [W-1:0]  prod8_top_i,
  input  logic [W-1:0]  prod8_bot_i,
  input  logic [RW-1:0] prod16_i,
  input  logic [1:0]    top_x_sel_i,
  input  logic [1:0]    bot_z_sel_i,
  input  logic          top_w_sel_i,
  input  logic          bot_y_sel_i,
  input  logic [1:0]    top_ci_sel_i,
  input  logic [1:0]    bot_ci_sel_i,
  input  logic [1:0]    top_out_sel_i,
  input  logic [1:0]    bot_out_sel_i,
  input  logic          top_sub_i,
  input  logic          bot_sub_i,
  input  logic          top_load_i,
  input  logic          bot_load_i,
  input  logic          top_hold_i,
  input  logic          bot_hold_i,
  input  logic          top_clr_i,
  input  logic          bot_clr_i,
  input  logic          casc_acc_ci_i,
  input  logic          casc_ci_i,
  input  logic          casc_sext_i,
  output logic [RW-1:0] result_o,
  output logic          co_o,
  output logic          acc_co_o,
  output logic          sext_o
);
  logic [W-1:0] bot_x, top_x, bot_acc, top_acc, bot_out, top_out;
  logic         bot_co, bot_acc_co;

  dacc_half #(.W(W)) u_bot (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i),
    .raw_i(b_i), .p8_i(prod8_bot_i), .p16_i(prod16_i[W-1:0]), .ext_i({W{casc_sext_i}}),
    .pre_i(d_i), .x_sel_i(bot_z_sel_i), .w_sel_i(bot_y_sel_i), .ci_sel_i(bot_ci_sel_i),
    .out_sel_i(bot_out_sel_i), .casc_acc_ci_i(casc_acc_ci_i), .casc_ci_i(casc_ci_i),
    .sub_i(bot_sub_i), .load_i(bot_load_i), .hold_i(bot_hold_i), .clr_i(bot_clr_i),
    .x_o(bot_x), .co_o(bot_co), .acc_o(bot_acc), .acc_co_o(bot_acc_co), .out_o(bot_out)
  );

  // top half cascades from bottom: sign of Z and both bottom carries
  dacc_half #(.W(W)) u_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i),
    .raw_i(a_i), .p8_i(prod8_top_i), .p16_i(prod16_i[RW-1:W]), .ext_i({W{bot_x[W-1]}}),
    .pre_i(c_i), .x_sel_i(top_x_sel_i), .w_sel_i(top_w_sel_i), .ci_sel_i(top_ci_sel_i),
    .out_sel_i(top_out_sel_i), .casc_acc_ci_i(bot_acc_co), .casc_ci_i(bot_co),
    .sub_i(top_sub_i), .load_i(top_load_i), .hold_i(top_hold_i), .clr_i(top_clr_i),
    .x_o(top_x), .co_o(co_o), .acc_o(top_acc), .acc_co_o(acc_co_o), .out_o(top_out)
  );

  assign result_o = {top_out, bot_out};
  assign sext_o   = top_x[W-1];
endmodule

// File: rtl/dacc_chk.sv
module dacc_chk #(
  parameter int W = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ce_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   c_i,
  input logic [W-1:0]   prod8_top_i,
  input logic [1:0]     top_x_sel_i,
  input logic [1:0]     top_out_sel_i,
  input logic           top_load_i,
  input logic           top_hold_i,
  input logic           top_clr_i,
  input logic [W-1:0]   top_acc_i,
  input logic [W-1:0]   bot_acc_i,
  input logic [2*W-1:0] result_o,
  input logic           sext_o
);
  // R6
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && top_clr_i |=> top_acc_i == '0);
  // R7
  load_over_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !top_clr_i && top_load_i |=> top_acc_i == $past(c_i));
  // R8
  hold_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !top_clr_i && !top_load_i && top_hold_i |=> $stable(top_acc_i));
  // R9
  ce_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(top_acc_i) && $stable(bot_acc_i));
  // R2
  sext_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_x_sel_i == 2'd0 |-> sext_o == a_i[W-1]);
  // R10
  out_p8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_out_sel_i == 2'd2 |-> result_o[2*W-1:W] == prod8_top_i);
endmodule

bind dual_accum_addsub dacc_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .a_i(a_i), .c_i(c_i),
  .prod8_top_i(prod8_top_i), .top_x_sel_i(top_x_sel_i), .top_out_sel_i(top_out_sel_i),
  .top_load_i(top_load_i), .top_hold_i(top_hold_i), .top_clr_i(top_clr_i),
  .top_acc_i(top_acc), .bot_acc_i(bot_acc), .result_o(result_o), .sext_o(sext_o)
);

// File: tb/dual_accum_addsub_tb.sv
module dual_accum_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce;
  logic [15:0] a, b, c, d, p8t, p8b;
  logic [31:0] p16;
  logic [1:0]  txs, bzs, tcs, bcs, tos, bos;
  logic        tws, bys, tsub, bsub, tld, bld, thd, bhd, tclr, bclr, cacc, cci, csx;
  logic [31:0] result;
  logic        co, acco, sext;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_tacc, m_bacc;
  logic        m_tc, m_bc;
  logic [16:0] e_ts, e_bs;
  logic [34:0] exp_v;

  always #5 clk = ~clk;

  dual_accum_addsub dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .a_i(a), .b_i(b), .c_i(c), .d_i(d),
    .prod8_top_i(p8t), .prod8_bot_i(p8b), .prod16_i(p16),
    .top_x_sel_i(txs), .bot_z_sel_i(bzs), .top_w_sel_i(tws), .bot_y_sel_i(bys),
    .top_ci_sel_i(tcs), .bot_ci_sel_i(bcs), .top_out_sel_i(tos), .bot_out_sel_i(bos),
    .top_sub_i(tsub), .bot_sub_i(bsub), .top_load_i(tld), .bot_load_i(bld),
    .top_hold_i(thd), .bot_hold_i(bhd), .top_clr_i(tclr), .bot_clr_i(bclr),
    .casc_acc_ci_i(cacc), .casc_ci_i(cci), .casc_sext_i(csx),
    .result_o(result), .co_o(co), .acc_co_o(acco), .sext_o(sext)
  );

  task automatic model_eval();
    logic [15:0] bz, by, tx, tw, tout, bout;
    logic bcin, tcin;
    case (bzs) 2'd0: bz = b; 2'd1: bz = p8b; 2'd2: bz = p16[15:0]; default: bz = {16{csx}}; endcase
    by = bys ? d : m_bacc;
    case (bcs) 2'd0: bcin = 0; 2'd1: bcin = 1; 2'd2: bcin = cacc; default: bcin = cci; endcase
    e_bs = {1'b0, by} + {1'b0, (bsub ? ~bz : bz)} + {16'd0, bcin};
    case (txs) 2'd0: tx = a; 2'd1: tx = p8t; 2'd2: tx = p16[31:16]; default: tx = {16{bz[15]}}; endcase
    tw = tws ? c : m_tacc;
    case (tcs) 2'd0: tcin = 0; 2'd1: tcin = 1; 2'd2: tcin = m_bc; default: tcin = e_bs[16]; endcase
    e_ts = {1'b0, tw} + {1'b0, (tsub ? ~tx : tx)} + {16'd0, tcin};
    case (tos) 2'd0: tout = e_ts[15:0]; 2'd1: tout = m_tacc; 2'd2: tout = p8t; default: tout = p16[31:16]; endcase
    case (bos) 2'd0: bout = e_bs[15:0]; 2'd1: bout = m_bacc; 2'd2: bout = p8b; default: bout = p16[15:0]; endcase
    exp_v = {tout, bout, e_ts[16], m_tc, tx[15]};
  endtask

  task automatic model_clk();
    if (ce) begin
      if (tclr) begin m_tacc = 0; m_tc = 0; end
      else if (tld) begin m_tacc = c; m_tc = 0; end
      else if (!thd) begin m_tacc = e_ts[15:0]; m_tc = e_ts[16]; end
      if (bclr) begin m_bacc = 0; m_bc = 0; end
      else if (bld) begin m_bacc = d; m_bc = 0; end
      else if (!bhd) begin m_bacc = e_bs[15:0]; m_bc = e_bs[16]; end
    end
  endtask

  task automatic compare(string tag);
    model_eval();
    checks++;
    if ({result, co, acco, sext} !== exp_v) begin
      fails++;
      $display("FAIL %s: actual res=%h co=%b acco=%b sext=%b expected res=%h co=%b acco=%b sext=%b",
               tag, result, co, acco, sext, exp_v[34:3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  // inputs set at negedge; check before edge; advance model at edge
  task automatic cyc(string tag);
    #1;
    compare(tag);
    @(posedge clk);
    model_clk();
    @(negedge clk);
  endtask

  task automatic defaults();
    ce = 1; a = 0; b = 0; c = 0; d = 0; p8t = 0; p8b = 0; p16 = 0;
    txs = 0; bzs = 0; tcs = 0; bcs = 0; tos = 0; bos = 0; tws = 0; bys = 0;
    tsub = 0; bsub = 0; tld = 0; bld = 0; thd = 0; bhd = 0; tclr = 0; bclr = 0;
    cacc = 0; cci = 0; csx = 0;
  endtask

  task automatic rand_data();
    a = 16'($urandom); b = 16'($urandom); c = 16'($urandom); d = 16'($urandom);
    p8t = 16'($urandom); p8b = 16'($urandom); p16 = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9137));
    defaults();
    m_tacc = 0; m_bacc = 0; m_tc = 0; m_bc = 0;
    tos = 1; bos = 1;
    repeat (2) @(negedge clk);
    cyc("R11 reset state");
    rst_ni = 1;
    @(negedge clk);
    // R1 bottom source codes
    bos = 0; bys = 1; tos = 0;
    for (int s = 0; s < 4; s++) begin rand_data(); bzs = 2'(s); csx = s[0]; cyc("R1"); end
    // R2 top source codes, sign extension from bottom Z
    tws = 1;
    for (int s = 0; s < 4; s++) begin rand_data(); txs = 2'(s); bzs = 0; b = 16'h8001; cyc("R2"); end
    b = 16'h7fff; txs = 3; cyc("R2 sext positive");
    // R3 W/Y select
    for (int s = 0; s < 4; s++) begin rand_data(); tws = s[0]; bys = s[1]; txs = 0; bzs = 0; cyc("R3"); end
    // R4 carry chain
    bys = 1; d = 16'h0001; bzs = 0; b = 16'hffff; bcs = 0; tws = 1; c = 16'h0010; txs = 0; a = 0;
    for (int s = 0; s < 4; s++) begin tcs = 2'(s); cyc("R4 top carry"); end
    tcs = 2; bhd = 1; d = 0; b = 0; cyc("R4 registered carry");
    bhd = 0;
    for (int s = 0; s < 8; s++) begin bcs = 2'(s); cacc = s[2]; cci = ~s[2]; cyc("R4 bottom carry"); end
    // R5 subtract
    tcs = 1; bcs = 1; tsub = 1; bsub = 1; c = 16'h0005; a = 16'h0007; d = 16'h1234; b = 16'h1234;
    cyc("R5 sub borrow");
    tcs = 0; a = 16'h0003; cyc("R5 sub no cin");
    tsub = 0; bsub = 0; c = 16'hfff0; a = 16'h0020; cyc("R5 add carry");
    // R7 load beats hold; then accumulate
    tws = 0; bys = 0; tos = 1; bos = 1; tld = 1; bld = 1; thd = 1; bhd = 1; c = 16'h1111; d = 16'h2222;
    cyc("R7 load"); tld = 0; bld = 0; cyc("R7 loaded value");
    // R8 hold, then accumulate
    a = 16'h0101; b = 16'h0202; cyc("R8 hold"); cyc("R8 hold 2");
    thd = 0; bhd = 0; cyc("R8 accumulate"); cyc("R8 accumulate 2");
    // R9 clock enable low with every control active
    ce = 0; tclr = 1; bld = 1; cyc("R9 ce low"); cyc("R9 ce low held");
    // R6 clear beats load
    ce = 1; tld = 1; cyc("R6 clear"); tclr = 0; tld = 0; bld = 0; thd = 1; bhd = 1; cyc("R6 cleared");
    // R10 output select codes
    for (int s = 0; s < 16; s++) begin rand_data(); tos = 2'(s); bos = 2'(s >> 2); cyc("R10"); end
    // R11 async reset mid-run
    tos = 1; bos = 1; rst_ni = 0; #2;
    m_tacc = 0; m_bacc = 0; m_tc = 0; m_bc = 0;
    compare("R11 async clear");
    @(negedge clk); rst_ni = 1; @(negedge clk);
    // constrained random
    for (int i = 0; i < 600; i++) begin
      rand_data();
      {txs, bzs, tcs, bcs, tos, bos} = 12'($urandom);
      {tws, bys, tsub, bsub, cacc, cci, csx} = 7'($urandom);
      ce = ($urandom % 8) != 0;
      tclr = ($urandom % 16) == 0; bclr = ($urandom % 16) == 0;
      tld = ($urandom % 8) == 0;  bld = ($urandom % 8) == 0;
      thd = ($urandom % 4) == 0;  bhd = ($urandom % 4) == 0;
      cyc("R5 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule